// File: doc/BRIEF.md
# Hot-Plug Interrupt Event Aggregator

This block collects event indications from a bank of hot-plug slots and from a command-completion source. It folds them into one 32-bit interrupt-locator word and turns that word into a single interrupt request. Every slot keeps a five-bit event latch and a seven-bit mask. Event pulses from the slot logic set latch bits, and software clears them by writing ones. A latched bit whose mask bit is clear marks the slot as pending in the locator.

Bit 0 of the locator belongs to command completion. Slot index s appears at locator bit s+1. The combined level is gated by a global interrupt disable. It either drives a legacy level line or, when message signalling is enabled, produces a one-cycle notify pulse each time the combined level changes. A small word-addressed register port gives software read access to the control word, the locator and the per-slot words, and write access to the control word and the per-slot words.

Top module: `hp_irq_aggregator`

## Requirements
- R1: After reset every slot mask reads 0x7F and every latch reads 0. The control word reads 0x0000000F, meaning all four disable bits are set and both detected flags are clear. The locator reads 0, and irq_o and msi_pulse_o are 0.
- R2: A one on slot_evt[s*5+b] sets latch bit b of slot s. The latch bits are presence (0), isolated fault (1), button (2), latch-lever (3) and connected fault (4). Writing a one to bit b of the slot word clears that latch bit. When a set and a clear of the same bit fall in the same cycle, the set wins.
- R3: The slot word sits at address 2+s. It holds the latch in bits 4:0 and the read/write mask in bits 14:8. Locator bit s+1 is 1 exactly when the latch ANDed with the inverse of mask bits 4:0 is nonzero. Mask bits 5 and 6 are stored but never gate the locator.
- R4: Locator bit 0 is 1 exactly when command-detected (control bit 16) is 1 and command-interrupt-disable (control bit 2) is 0.
- R5: The control word sits at address 0. Bits 0 to 3 (interrupt disable, error-report disable, command-interrupt disable, arbiter error disable) are read/write. A cmd_done pulse sets bit 16 and an arb_evt pulse sets bit 17. Both bits are write-one-to-clear, and bit 17 never affects the locator.
- R6: The combined level is 1 when control bit 0 is 0 and the locator is nonzero. While msi_en is 0, irq_o equals the combined level one cycle late. While msi_en is 1, irq_o is 0.
- R7: A requested-level register, reset to 0, copies the combined level every cycle. msi_pulse_o is 1 for one cycle, one cycle after the level changes, but only if msi_en was 1 when the change was seen. Enabling msi_en while the level is already high gives no pulse.
- R8: A read returns data on rd_data one cycle after rd_en. Address 1 returns the locator. Locator bits above NUM_SLOTS read 0, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| slot_evt | input | NUM_SLOTS*5 | Per-slot event set pulses, five bits per slot |
| cmd_done | input | 1 | Command completion pulse |
| arb_evt | input | 1 | Arbiter event pulse |
| msi_en | input | 1 | Message signalling enabled |
| rd_data | output | 32 | Registered read data |
| irq_o | output | 1 | Legacy level interrupt |
| msi_pulse_o | output | 1 | One-cycle notify request |

## Verification
Latch and control state change on the clock edge that samples a write or event pulse. The locator follows combinationally, so a read issued on the next cycle already sees it. irq_o and msi_pulse_o come from registers fed by the locator, so each is due one edge after the state edge. The bench drives on falling edges and samples both outputs at the falling edge just after that second edge. It also checks them at the earlier falling edge, so that a version missing the register stage is caught. Read data is checked one edge after rd_en.

// File: rtl/hp_irq_pkg.sv
package hp_irq_pkg;
  localparam int REG_W       = 32;
  localparam int EVT_W       = 5;
  localparam int MASK_W      = 7;
  localparam int MASK_LSB    = 8;
  // control word bit positions
  localparam int C_INT_DIS   = 0;
  localparam int C_SERR_DIS  = 1;
  localparam int C_CMD_DIS   = 2;
  localparam int C_ARB_DIS   = 3;
  localparam int C_CMD_DET   = 16;
  localparam int C_ARB_DET   = 17;
  // address map
  localparam int A_CTRL      = 0;
  localparam int A_LOC       = 1;
  localparam int A_SLOT0     = 2;

  typedef struct packed {
    logic arb_dis;
    logic cmd_dis;
    logic serr_dis;
    logic int_dis;
  } dis_t;
endpackage

// File: rtl/hp_slot_evt.sv
module hp_slot_evt
  import hp_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  logic [EVT_W-1:0]  clr_bits,
  input  logic [MASK_W-1:0] mask_wr,
  input  logic [EVT_W-1:0]  evt_set,
  output logic [EVT_W-1:0]  latch_o,
  output logic [MASK_W-1:0] mask_o,
  output logic              pend_o
);
  logic [EVT_W-1:0]  latch_q;
  logic [MASK_W-1:0] mask_q;
  logic [EVT_W-1:0]  clr_eff;

  assign clr_eff = wr_hit ? clr_bits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      mask_q  <= '1;
    end else begin
      latch_q <= (latch_q & ~clr_eff) | evt_set;
      if (wr_hit) mask_q <= mask_wr;
    end
  end

  assign latch_o = latch_q;
  assign mask_o  = mask_q;
  assign pend_o  = |(latch_q & ~mask_q[EVT_W-1:0]);

  // R2
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|evt_set) |=> ((latch_q & $past(evt_set)) == $past(evt_set)));
  // R2
  w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && evt_set == '0) |=> ((latch_q & $past(clr_bits)) == '0));
endmodule

// File: rtl/hp_ctl_reg.sv
module hp_ctl_reg
  import hp_irq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_hit,
  input  logic [3:0] dis_wr,
  input  logic cmd_clr,
  input  logic arb_clr,
  input  logic cmd_done,
  input  logic arb_evt,
  output dis_t dis_o,
  output logic cmd_det_o,
  output logic arb_det_o
);
  dis_t dis_q;
  logic cmd_q, arb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dis_q <= '1;
      cmd_q <= 1'b0;
      arb_q <= 1'b0;
    end else begin
      if (wr_hit) dis_q <= dis_t'(dis_wr);
      cmd_q <= (cmd_q & ~(wr_hit & cmd_clr)) | cmd_done;
      arb_q <= (arb_q & ~(wr_hit & arb_clr)) | arb_evt;
    end
  end

  assign dis_o     = dis_q;
  assign cmd_det_o = cmd_q;
  assign arb_det_o = arb_q;

  // R5
  cmd_set_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_done |=> cmd_q);
  // R5
  arb_set_chk: assert property (@(posedge clk) disable iff (rst)
    arb_evt |=> arb_q);
endmodule

// File: rtl/hp_irq_out.sv
module hp_irq_out (
  input  logic clk,
  input  logic rst,
  input  logic any_src,
  input  logic int_dis,
  input  logic msi_en,
  output logic irq_o,
  output logic msi_pulse_o
);
  logic level;
  logic req_q, irq_q, msi_q;

  assign level = any_src & ~int_dis;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      irq_q <= 1'b0;
      msi_q <= 1'b0;
    end else begin
      req_q <= level;
      irq_q <= level & ~msi_en;
      msi_q <= msi_en & (level != req_q);
    end
  end

  assign irq_o       = irq_q;
  assign msi_pulse_o = msi_q;

  // R7
  msi_on_change_chk: assert property (@(posedge clk) disable iff (rst)
    msi_q |-> (req_q != $past(req_q)));
  // R7
  msi_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    msi_q |-> $past(msi_en));
  // R6
  irq_quiet_msi_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> !$past(msi_en));
endmodule

// File: rtl/hp_irq_aggregator.sv
module hp_irq_aggregator
  import hp_irq_pkg::*;
#(
  parameter int NUM_SLOTS = 31,
  parameter int ADDR_W    = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [REG_W-1:0]           wdata,
  input  logic [NUM_SLOTS*EVT_W-1:0] slot_evt,
  input  logic                       cmd_done,
  input  logic                       arb_evt,
  input  logic                       msi_en,
  output logic [REG_W-1:0]           rd_data,
  output logic                       irq_o,
  output logic                       msi_pulse_o
);
  localparam int LAST_ADDR = A_SLOT0 + NUM_SLOTS - 1;

  logic [EVT_W-1:0]  latch_a [NUM_SLOTS];
  logic [MASK_W-1:0] mask_a  [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] pend;
  logic [REG_W-1:0] loc;
  logic [REG_W-1:0] rd_next;
  logic [REG_W-1:0] rd_q;
  dis_t dis;
  logic cmd_det, arb_det;
  logic ctl_hit;
  logic unused_wdata;

  assign unused_wdata = ^{wdata[REG_W-1:18], wdata[15], wdata[7:5]};
  assign ctl_hit = wr_en && (addr == ADDR_W'(A_CTRL));

  hp_ctl_reg u_ctl (
    .clk(clk), .rst(rst), .wr_hit(ctl_hit),
    .dis_wr(wdata[C_ARB_DIS:C_INT_DIS]),
    .cmd_clr(wdata[C_CMD_DET]), .arb_clr(wdata[C_ARB_DET]),
    .cmd_done(cmd_done), .arb_evt(arb_evt),
    .dis_o(dis), .cmd_det_o(cmd_det), .arb_det_o(arb_det)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic hit;
    assign hit = wr_en && (addr == ADDR_W'(A_SLOT0 + s));
    hp_slot_evt u_slot (
      .clk(clk), .rst(rst), .wr_hit(hit),
      .clr_bits(wdata[EVT_W-1:0]),
      .mask_wr(wdata[MASK_LSB +: MASK_W]),
      .evt_set(slot_evt[s*EVT_W +: EVT_W]),
      .latch_o(latch_a[s]), .mask_o(mask_a[s]), .pend_o(pend[s])
    );
  end

  always_comb begin
    loc = '0;
    loc[0] = cmd_det & ~dis.cmd_dis;
    loc[NUM_SLOTS:1] = pend;
  end

  hp_irq_out u_out (
    .clk(clk), .rst(rst), .any_src(|loc), .int_dis(dis.int_dis),
    .msi_en(msi_en), .irq_o(irq_o), .msi_pulse_o(msi_pulse_o)
  );

  always_comb begin
    rd_next = '0;
    if (addr == ADDR_W'(A_CTRL)) begin
      rd_next[C_ARB_DIS:C_INT_DIS] = dis;
      rd_next[C_CMD_DET] = cmd_det;
      rd_next[C_ARB_DET] = arb_det;
    end else if (addr == ADDR_W'(A_LOC)) begin
      rd_next = loc;
    end else begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (addr == ADDR_W'(A_SLOT0 + s)) begin
          rd_next[EVT_W-1:0] = latch_a[s];
          rd_next[MASK_LSB +: MASK_W] = mask_a[s];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else if (rd_en) rd_q <= rd_next;
  end

  assign rd_data = rd_q;

  // R8
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && int'(addr) > LAST_ADDR) |=> (rd_data == '0));
  // R4
  cmd_loc_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_done && !dis.cmd_dis && !(ctl_hit && wdata[C_CMD_DIS])) |=> loc[0]);
endmodule

// File: tb/hp_irq_aggregator_tb.sv
`timescale 1ns/1ps
module hp_irq_aggregator_tb;
  localparam int NS = 31;
  localparam int AW = 6;

  logic clk = 0;
  logic rst = 1;
  logic wr_en = 0, rd_en = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [NS*5-1:0] slot_evt = '0;
  logic cmd_done = 0, arb_evt = 0, msi_en = 0;
  logic [31:0] rd_data;
  logic irq_o, msi_pulse_o;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  hp_irq_aggregator #(.NUM_SLOTS(NS), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .slot_evt(slot_evt), .cmd_done(cmd_done),
    .arb_evt(arb_evt), .msi_en(msi_en), .rd_data(rd_data),
    .irq_o(irq_o), .msi_pulse_o(msi_pulse_o)
  );

  // {slot[4:0], evt[4:0], mask[6:0], expect_pending}
  localparam logic [17:0] VEC [8] = '{
    {5'd0,  5'h01, 7'h00, 1'b1},
    {5'd3,  5'h04, 7'h04, 1'b0},
    {5'd3,  5'h0C, 7'h04, 1'b1},
    {5'd30, 5'h10, 7'h0F, 1'b1},
    {5'd30, 5'h10, 7'h1F, 1'b0},
    {5'd7,  5'h02, 7'h60, 1'b1},
    {5'd12, 5'h1F, 7'h1E, 1'b1},
    {5'd1,  5'h08, 7'h7F, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = AW'(a); wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = AW'(a);
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  task automatic evt(input int s, input logic [4:0] b);
    @(negedge clk); slot_evt[s*5 +: 5] = b;
    @(negedge clk); slot_evt = '0;
  endtask

  initial begin
    #(5.0 * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    rd(0, d); chk("R1 ctrl", d, 32'h0000000F);
    rd(2, d); chk("R1 slot0", d, 32'h00007F00);
    rd(32, d); chk("R1 slot30", d, 32'h00007F00);
    rd(1, d); chk("R1 locator", d, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    chk("R1 msi", {31'b0, msi_pulse_o}, 32'h0);

    // R2 R3 R8 vector table
    foreach (VEC[i]) begin
      int s; logic [4:0] e; logic [6:0] m; logic p;
      {s, e, m, p} = {27'b0, VEC[i]};
      wr(2 + s, {17'b0, m, 8'h00});
      evt(s, e);
      rd(2 + s, d); chk("R2 latch", d, {17'b0, m, 3'b0, e});
      rd(1, d); chk("R3 locator", d, p ? (32'h1 << (s + 1)) : 32'h0);
      wr(2 + s, {17'b0, m, 8'h1F});
      rd(2 + s, d); chk("R2 w1c", d, {17'b0, m, 8'h00});
      rd(1, d); chk("R3 locator after clear", d, 32'h0);
    end

    // R4 R5 command detected
    @(negedge clk); cmd_done = 1; @(negedge clk); cmd_done = 0;
    rd(0, d); chk("R5 cmd set", d, 32'h0001000F);
    rd(1, d); chk("R4 masked", d, 32'h0);
    wr(0, 32'h0000000B);
    rd(1, d); chk("R4 unmasked", d, 32'h1);
    chk("R6 int_dis gates irq", {31'b0, irq_o}, 32'h0);
    wr(0, 32'h0001000B);
    rd(0, d); chk("R5 cmd w1c", d, 32'h0000000B);
    rd(1, d); chk("R4 cleared", d, 32'h0);
    @(negedge clk); arb_evt = 1; @(negedge clk); arb_evt = 0;
    rd(0, d); chk("R5 arb set", d, 32'h0002000B);
    rd(1, d); chk("R5 arb no locator", d, 32'h0);
    wr(0, 32'h0002000B);
    rd(0, d); chk("R5 arb w1c", d, 32'h0000000B);

    // R6 legacy line
    wr(0, 32'h0);
    wr(4, 32'h0);
    evt(2, 5'h01);
    chk("R6 irq one cycle late", {31'b0, irq_o}, 32'h0);
    @(negedge clk); chk("R6 irq high", {31'b0, irq_o}, 32'h1);
    chk("R7 no msi when disabled", {31'b0, msi_pulse_o}, 32'h0);
    wr(0, 32'h1);
    @(negedge clk); chk("R6 int_dis drops irq", {31'b0, irq_o}, 32'h0);
    wr(0, 32'h0);
    @(negedge clk); chk("R6 irq restored", {31'b0, irq_o}, 32'h1);
    wr(4, 32'h01);
    @(negedge clk); chk("R6 irq after clear", {31'b0, irq_o}, 32'h0);

    // R7 notify pulses
    @(negedge clk); msi_en = 1;
    evt(2, 5'h01);
    chk("R7 msi not early", {31'b0, msi_pulse_o}, 32'h0);
    @(negedge clk);
    chk("R7 msi rise pulse", {31'b0, msi_pulse_o}, 32'h1);
    chk("R6 irq quiet with msi", {31'b0, irq_o}, 32'h0);
    @(negedge clk); chk("R7 msi one cycle", {31'b0, msi_pulse_o}, 32'h0);
    wr(4, 32'h01);
    @(negedge clk); chk("R7 msi fall pulse", {31'b0, msi_pulse_o}, 32'h1);
    @(negedge clk); chk("R7 msi fall end", {31'b0, msi_pulse_o}, 32'h0);
    msi_en = 0;
    evt(2, 5'h01);
    @(negedge clk); msi_en = 1;
    @(negedge clk);
    chk("R7 no pulse on enable", {31'b0, msi_pulse_o}, 32'h0);
    chk("R6 irq off under msi", {31'b0, irq_o}, 32'h0);
    @(negedge clk); chk("R7 still no pulse", {31'b0, msi_pulse_o}, 32'h0);
    msi_en = 0;
    wr(4, 32'h01);

    // R2 set wins over same-cycle clear
    evt(2, 5'h02);
    @(negedge clk); wr_en = 1; addr = AW'(4); wdata = 32'h03; slot_evt[10] = 1'b1;
    @(negedge clk); wr_en = 0; slot_evt = '0;
    rd(4, d); chk("R2 set wins", d, 32'h00000001);

    // R8 unmapped
    rd(33, d); chk("R8 unmapped", d, 32'h0);
    rd(63, d); chk("R8 unmapped top", d, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule